// File: doc/BRIEF.md
# Line-Rate Search Controller

This block belongs to one receive channel of a multi-rate serial transceiver. It finds the bit rate of an incoming link by trial. It steps through up to eight candidate rate settings and holds each one for a programmable dwell time. During that time it waits for the channel-synchronization logic to report that the link is in sync. While it is active, it takes over the transmit-rate, receive-rate and PLL-multiplier settings words, using the values stored for the candidate under test.

Once it is locked, the controller keeps watching the sync indication. If sync drops, it tries the same rate once more for a full dwell period. It then moves down through the lower enabled rates. It goes back to the highest enabled rate only when no lower rate is left. An optional interrupt-style output shows the inverse of the lock flag.

Top module: `line_rate_search`

## Requirements
- R1: The effective enable comes from `mode_sel`. Code 3'b100 uses `sw_enable`. Codes 3'b101, 3'b110 and 3'b111 use `pin_enable`. Codes 3'b000 to 3'b011 keep the controller idle, whatever the two enable inputs are.
- R2: Rate index 7 is the highest rate and index 0 the lowest. On start the controller goes to the highest index whose bit in `rate_mask` is 1. Each timeout moves it to the next lower enabled index and skips disabled ones. After the lowest enabled index it wraps to the highest enabled index.
- R3: When no sync is accepted, every candidate is held for exactly max(`dwell_ivl`,1) x 1024 clock cycles, counted from the clock edge that selected it.
- R4: `locked` rises on the clock edge after the qualified sync (`sync_ok` AND `cdr_lock`) has been sampled high on two consecutive edges. A one-cycle sync pulse does not lock. Sync while `cdr_lock` is low does not lock.
- R5: While `locked` is high, `rate_idx` does not change. When the qualified sync goes low, `locked` falls on the next edge and the same index is retried for one full dwell period.
- R6: After a failed retry, the next candidate is the next lower enabled index. If there is none, it is the highest enabled index.
- R7: When the effective enable goes low, `override_active` and `locked` are low after the next clock edge.
- R8: With `rate_mask` equal to zero, the controller stays idle. `override_active` and `locked` stay low and the index does not cycle.
- R9: The settings outputs follow `rate_idx` = i as follows. `tx_rate` = i[2:1], `rx_rate` = i[2:1] and `pll_mult` = i + 3.
- R10: `loss_irq` equals NOT `locked` when `loss_irq_en` is 1. It is 0 when `loss_irq_en` is 0.
- R11: After reset, `override_active` and `locked` are low and `rate_idx` is 0. `override_active` is high whenever the controller is searching or locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Chooses the enable source |
| sw_enable | input | 1 | Register-driven enable |
| pin_enable | input | 1 | Externally driven enable |
| rate_mask | input | 8 | One enable bit per candidate rate index |
| dwell_ivl | input | 21 | Dwell time per candidate, in units of 1024 cycles |
| sync_ok | input | 1 | Channel-synchronization status |
| cdr_lock | input | 1 | Clock-recovery lock; qualifies sync |
| loss_irq_en | input | 1 | Enables the inverted-lock output |
| rate_idx | output | 3 | Candidate index under test |
| tx_rate | output | 2 | Override transmit-rate code |
| rx_rate | output | 2 | Override receive-rate code |
| pll_mult | output | 4 | Override PLL multiplier |
| override_active | output | 1 | Settings override in force |
| locked | output | 1 | A rate has been found and sync holds |
| loss_irq | output | 1 | Inverse of locked when enabled |

## Verification
The bench measures the exact dwell on every candidate. A timer that is off by one, or that treats an interval of zero as zero length, shows up as a wrong cycle count. Sparse masks exercise the downward order. A controller that failed to skip disabled entries, or that wrapped wrongly, would move to an unexpected index. The loss path is timed cycle by cycle, both from a middle candidate and from the lowest one. A design that skipped the single retry, or jumped to the highest rate too early, would leave the locked index one dwell period too soon or land on the wrong one. Short sync pulses, sync without clock-recovery lock, an empty mask and the enable codes that select neither source must all leave the controller unlocked or idle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RS_NUM         = 8;
  localparam int unsigned RS_IDX_W       = 3;
  localparam int unsigned RS_IVL_W       = 21;
  localparam int unsigned RS_DWELL_SHIFT = 10;
  localparam int unsigned RS_CNT_W       = RS_IVL_W + RS_DWELL_SHIFT;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_HUNT = 2'd1, ST_LOCK = 2'd2} rs_state_e;

  typedef struct packed {
    logic [1:0] tx;
    logic [1:0] rx;
    logic [3:0] pll;
  } rate_cfg_t;

  // Settings per candidate index, computed rather than tabulated.
  function automatic rate_cfg_t rate_entry(input logic [RS_IDX_W-1:0] idx);
    rate_cfg_t c;
    c.tx  = idx[2:1];
    c.rx  = idx[2:1];
    c.pll = 4'(idx) + 4'd3;
    return c;
  endfunction

  // Dwell in cycles: interval (zero taken as one) times 2^shift.
  function automatic logic [RS_CNT_W-1:0] dwell_limit(input logic [RS_IVL_W-1:0] ivl);
    logic [RS_IVL_W-1:0] eff;
    eff = (ivl == '0) ? RS_IVL_W'(1) : ivl;
    return RS_CNT_W'(eff) << RS_DWELL_SHIFT;
  endfunction

  function automatic logic [RS_IDX_W-1:0] highest_on(input logic [RS_NUM-1:0] mask);
    logic [RS_IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < int'(RS_NUM); i++)
      if (mask[i]) r = RS_IDX_W'(i);
    return r;
  endfunction

  // Next enabled index below cur; wraps to the highest enabled one.
  function automatic logic [RS_IDX_W-1:0] next_lower(input logic [RS_NUM-1:0] mask,
                                                     input logic [RS_IDX_W-1:0] cur);
    logic [RS_IDX_W-1:0] r;
    r = highest_on(mask);
    for (int i = 0; i < int'(RS_NUM); i++)
      if (i < int'(cur) && mask[i]) r = RS_IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/rs_enable_sel.sv
module rs_enable_sel (
  input  logic [2:0] mode_sel,
  input  logic       sw_enable,
  input  logic       pin_enable,
  output logic       en_o
);
  always_comb begin
    unique case (mode_sel)
      3'b100:                 en_o = sw_enable;
      3'b101, 3'b110, 3'b111: en_o = pin_enable;
      default:                en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rs_sync_qual.sv
module rs_sync_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_ok,
  input  logic cdr_lock,
  output logic qual_o,
  output logic accept_o
);
  logic qual_q;

  assign qual_o   = sync_ok & cdr_lock;
  assign accept_o = qual_o & qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_q <= 1'b0;
    else        qual_q <= qual_o;
  end
endmodule

// File: rtl/rs_dwell_timer.sv
module rs_dwell_timer #(
  parameter int unsigned CNT_W = rs_pkg::RS_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;

  assign expire_o = run && (count_q >= limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         count_q <= '0;
    else if (!run || restart || expire_o) count_q <= '0;
    else                                count_q <= count_q + CNT_W'(1);
  end

  AST_TIMER_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(limit) && $past(run)) |-> (count_q < limit)); // R3
endmodule

// File: rtl/line_rate_search.sv
module line_rate_search
  import rs_pkg::*;
#(
  parameter int unsigned NUM_RATES = rs_pkg::RS_NUM,
  parameter int unsigned IDX_W     = rs_pkg::RS_IDX_W,
  parameter int unsigned IVL_W     = rs_pkg::RS_IVL_W,
  localparam int unsigned CNT_W    = IVL_W + rs_pkg::RS_DWELL_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           mode_sel,
  input  logic                 sw_enable,
  input  logic                 pin_enable,
  input  logic [NUM_RATES-1:0] rate_mask,
  input  logic [IVL_W-1:0]     dwell_ivl,
  input  logic                 sync_ok,
  input  logic                 cdr_lock,
  input  logic                 loss_irq_en,
  output logic [IDX_W-1:0]     rate_idx,
  output logic [1:0]           tx_rate,
  output logic [1:0]           rx_rate,
  output logic [3:0]           pll_mult,
  output logic                 override_active,
  output logic                 locked,
  output logic                 loss_irq
);
  rs_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  // Named internal events
  logic en_eff;
  logic sync_qual;
  logic sync_accept;
  logic dwell_expire;
  logic cand_change;
  logic hunting;
  rate_cfg_t cfg;

  rs_enable_sel u_en (
    .mode_sel  (mode_sel),
    .sw_enable (sw_enable),
    .pin_enable(pin_enable),
    .en_o      (en_eff)
  );

  rs_sync_qual u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_ok (sync_ok),
    .cdr_lock(cdr_lock),
    .qual_o  (sync_qual),
    .accept_o(sync_accept)
  );

  assign hunting = (state_q == ST_HUNT);

  rs_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (hunting),
    .restart (cand_change),
    .limit   (dwell_limit(dwell_ivl)),
    .expire_o(dwell_expire)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (!en_eff || rate_mask == '0) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_HUNT;
          idx_d   = highest_on(rate_mask);
        end
        ST_HUNT: begin
          if (sync_accept)       state_d = ST_LOCK;
          else if (dwell_expire) idx_d   = next_lower(rate_mask, idx_q);
        end
        ST_LOCK: begin
          if (!sync_qual) state_d = ST_HUNT;  // retry same index
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign cand_change = (state_d != state_q) || (idx_d != idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign cfg             = rate_entry(idx_q);
  assign rate_idx        = idx_q;
  assign tx_rate         = cfg.tx;
  assign rx_rate         = cfg.rx;
  assign pll_mult        = cfg.pll;
  assign override_active = (state_q != ST_IDLE);
  assign locked          = (state_q == ST_LOCK);
  assign loss_irq        = loss_irq_en & ~locked;

  AST_LOCK_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(sync_ok && cdr_lock)); // R4
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_eff |=> (!override_active && !locked)); // R7
  AST_EMPTY_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_mask == '0) |=> (!override_active && !locked)); // R8
  AST_IDX_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(rate_idx)); // R5
  AST_RETRY_SAME_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $stable(rate_idx)); // R5
endmodule

// File: tb/tb_line_rate_search.sv
`timescale 1ns/1ps
module tb_line_rate_search;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic       sw_enable = 1'b0, pin_enable = 1'b0;
  logic [7:0] rate_mask = 8'h00;
  logic [20:0] dwell_ivl = 21'd1;
  logic       sync_ok = 1'b0, cdr_lock = 1'b0, loss_irq_en = 1'b0;
  logic [2:0] rate_idx;
  logic [1:0] tx_rate, rx_rate;
  logic [3:0] pll_mult;
  logic       override_active, locked, loss_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int idx; int dwell; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  line_rate_search dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_enable(sw_enable),
    .pin_enable(pin_enable), .rate_mask(rate_mask), .dwell_ivl(dwell_ivl),
    .sync_ok(sync_ok), .cdr_lock(cdr_lock), .loss_irq_en(loss_irq_en),
    .rate_idx(rate_idx), .tx_rate(tx_rate), .rx_rate(rx_rate), .pll_mult(pll_mult),
    .override_active(override_active), .locked(locked), .loss_irq(loss_irq)
  );

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver side of the scoreboard
  task automatic expect_move(input int idx, input int dwell);
    exp_t e;
    e.idx = idx; e.dwell = dwell;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int pll_of(input int i);
    return (i + 3) % 16;
  endfunction

  // Monitor: every new candidate is popped and compared (R2, R3)
  int  cyc = 0;
  int  last_change = 0;
  bit  prev_ovr = 0;
  int  prev_idx = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (override_active && (!prev_ovr || int'(rate_idx) != prev_idx)) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: unexpected move, actual %0d expected none", rate_idx);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check_val("R2 candidate order", int'(rate_idx), e.idx);
          if (e.dwell != 0) check_val("R3 dwell length", cyc - last_change, e.dwell);
        end
        last_change = cyc;
      end
      prev_ovr = override_active;
      prev_idx = int'(rate_idx);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    cycles(5);
    // R11 reset state
    check_val("R11 reset override", override_active, 0);
    check_val("R11 reset locked", locked, 0);
    check_val("R11 reset index", rate_idx, 0);
    rst_n = 1'b1;
    cycles(2);

    // R1: codes 000..011 keep it idle
    rate_mask = 8'hFF; sw_enable = 1; pin_enable = 1; mode_sel = 3'b011;
    cycles(5);
    check_val("R1 mode 011 idle", override_active, 0);

    // R1: pin source, software bit ignored
    sw_enable = 0; mode_sel = 3'b101;
    expect_move(7, 0);
    cycles(2);
    check_val("R1 pin enable active", override_active, 1);
    check_val("R11 override while hunting", override_active, 1);
    drain();
    mode_sel = 3'b110; pin_enable = 0; sw_enable = 1;
    cycles(1);
    check_val("R7 disable override", override_active, 0);
    check_val("R7 disable locked", locked, 0);
    cycles(3);
    check_val("R1 mode 110 ignores sw", override_active, 0);

    // R8: empty mask
    mode_sel = 3'b100; sw_enable = 1; rate_mask = 8'h00;
    cycles(3000);
    check_val("R8 empty mask override", override_active, 0);
    check_val("R8 empty mask locked", locked, 0);
    sw_enable = 0; cycles(2);

    // R2/R3: full sweep, 1024-cycle dwell
    rate_mask = 8'hFF; dwell_ivl = 21'd1;
    expect_move(7, 0);
    for (int i = 6; i >= 0; i--) expect_move(i, 1024);
    expect_move(7, 1024);
    sw_enable = 1;
    drain();
    sw_enable = 0; cycles(2);

    // R2/R3: sparse mask, interval 2
    rate_mask = 8'b0101_0010; dwell_ivl = 21'd2;
    expect_move(6, 0); expect_move(4, 2048); expect_move(1, 2048); expect_move(6, 2048);
    sw_enable = 1;
    drain();
    sw_enable = 0; cycles(2);

    // R3: zero interval taken as one
    rate_mask = 8'h81; dwell_ivl = 21'd0;
    expect_move(7, 0); expect_move(0, 1024); expect_move(7, 1024);
    sw_enable = 1;
    drain();
    sw_enable = 0; cycles(2);

    // Lock / loss scenario
    rate_mask = 8'b0101_0010; dwell_ivl = 21'd1; loss_irq_en = 1;
    expect_move(6, 0); expect_move(4, 1024);
    sw_enable = 1;
    drain();
    check_val("R10 loss high unlocked", loss_irq, 1);
    sync_ok = 1; cdr_lock = 0;
    cycles(3);
    check_val("R4 no lock without cdr", locked, 0);
    sync_ok = 0; cdr_lock = 1;
    cycles(1);
    sync_ok = 1; cycles(1); sync_ok = 0;
    cycles(2);
    check_val("R4 short pulse no lock", locked, 0);
    sync_ok = 1;
    cycles(1);
    check_val("R4 not yet locked", locked, 0);
    cycles(1);
    check_val("R4 locked", locked, 1);
    check_val("R9 tx code", tx_rate, 2);
    check_val("R9 rx code", rx_rate, 2);
    check_val("R9 pll mult", pll_mult, pll_of(4));
    check_val("R10 loss low locked", loss_irq, 0);
    cycles(3000);
    check_val("R5 still locked", locked, 1);
    check_val("R5 index held", rate_idx, 4);
    sync_ok = 0;
    expect_move(1, 0);
    cycles(1);
    check_val("R5 lock drops", locked, 0);
    check_val("R5 retry same index", rate_idx, 4);
    cycles(1023);
    check_val("R5 retry full dwell", rate_idx, 4);
    cycles(1);
    check_val("R6 next lower after retry", rate_idx, 1);
    sync_ok = 1;
    cycles(2);
    check_val("R4 locked at lowest", locked, 1);
    check_val("R9 pll at index 1", pll_mult, pll_of(1));
    check_val("R9 tx at index 1", tx_rate, 0);
    sync_ok = 0;
    expect_move(6, 0);
    cycles(1);
    check_val("R5 lock drops at lowest", locked, 0);
    cycles(1023);
    check_val("R5 retry lowest full dwell", rate_idx, 1);
    cycles(1);
    check_val("R6 wrap to highest", rate_idx, 6);
    loss_irq_en = 0;
    cycles(1);
    check_val("R10 loss gated off", loss_irq, 0);
    sw_enable = 0;
    cycles(1);
    check_val("R7 disable releases override", override_active, 0);
    drain();

    done = 1;
    summary();
  end
endmodule